// File: doc/BRIEF.md
# Card Attribute-Space Configuration Controller

This block answers the attribute-memory side of a PC-card style host bus. It serves two things: a read-only card information table, and one configuration option register. From that register it also drives the reset for the rest of the device. The host presents a 17-bit address, byte data, read and write strobes, and an attribute-space select. Nothing responds unless the attribute-space select is high.

After a hardware reset the block fetches the 492 table bytes, one at a time, through a request/acknowledge byte port from an EEPROM model. It stores them in the upper half of a local SRAM and reports busy until the last byte is stored. A soft reset can be started and ended from the option register. The soft reset keeps the table and the configuration index, and it does not fetch from the EEPROM again. A hardware reset clears everything and runs the fetch again.

Top module: `pccard_attr_cfg`

## Requirements
- R1: From hardware reset until the table load finishes, `busy` is 1 and a host read of any table offset returns 0xFF.
- R2: The load makes exactly 492 EEPROM byte fetches, for table addresses 0 upward. Then `busy` falls and `ee_req` stays low.
- R3: After the load, table byte n (n = 0 to 491) reads back at the even attribute offset 2n. The read data appears on `hd_out` one clock after the read strobe.
- R4: Any odd attribute offset reads 0xFF. An even offset that is neither in the table nor the option register also reads 0xFF.
- R5: The option register is at offset 0x0FD0. It reads as {bit 7 = soft-reset flag, bit 6 = 1, bits 5:0 = configuration index}. Bits 5:0 come from a write with bit 7 = 0 while the flag is clear. Bit 6 always reads 1, whatever value is written to it.
- R6: A write with bit 7 = 1 sets the flag. `soft_rst` and `core_rst` are high from the next clock on. The index bits in that write are discarded.
- R7: While the flag is set, a write with bit 7 = 1 changes neither the flag nor the index.
- R8: A write with bit 7 = 0 while the flag is set clears it. The index keeps its value from before the soft reset, and the index bits in the releasing write are discarded. The table contents stay as they were, `busy` stays 0, and no EEPROM fetch takes place.
- R9: A hardware reset clears the flag, so the register reads 0x40 and `soft_rst` goes to 0. It then reruns the full load.
- R10: `core_rst` is high whenever `soft_rst` is high or `rst_n` is low.
- R11: A read or write strobe with `h_attr` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ha | input | 17 | Host address |
| hd_in | input | 8 | Host write data |
| hd_out | output | 8 | Host read data, registered |
| h_rd | input | 1 | Read strobe |
| h_wr | input | 1 | Write strobe |
| h_attr | input | 1 | Attribute-space select |
| busy | output | 1 | Table load in progress |
| ee_req | output | 1 | EEPROM byte request |
| ee_addr | output | 9 | EEPROM byte address |
| ee_ack | input | 1 | EEPROM byte valid |
| ee_data | input | 8 | EEPROM byte |
| soft_rst | output | 1 | Soft reset flag |
| core_rst | output | 1 | Reset to the device core |

## Verification
The hardest case to reach is the preservation claim. Showing that a soft reset keeps the index and the table, and fetches nothing, requires a prior state that differs from the reset state. The stimulus therefore writes a distinctive index first and sets the flag with other index bits in the same write. It then writes a third index pattern while the flag is held, and releases with yet another. Throughout, the bench counts EEPROM acknowledges and reads back table bytes against its own model of the EEPROM contents. A hardware reset taken while the flag is set then shows the opposite path: the register clears and all 492 fetches run again.

// File: rtl/pccard_attr_cfg.sv
module pccard_attr_cfg #(
  parameter int ADDR_W    = 17,
  parameter int TBL_BYTES = 492,
  parameter int SRAM_AW   = 10,
  parameter int IDX_W     = 6,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 17'h00FD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ha,
  input  logic [7:0]        hd_in,
  output logic [7:0]        hd_out,
  input  logic              h_rd,
  input  logic              h_wr,
  input  logic              h_attr,
  output logic              busy,
  output logic              ee_req,
  output logic [SRAM_AW-2:0] ee_addr,
  input  logic              ee_ack,
  input  logic [7:0]        ee_data,
  output logic              soft_rst,
  output logic              core_rst
);
  localparam int TBL_AW     = SRAM_AW - 1;
  localparam int SRAM_DEPTH = 1 << SRAM_AW;
  localparam logic [TBL_AW-1:0] LAST_IDX  = TBL_AW'(TBL_BYTES - 1);
  localparam logic [ADDR_W-2:0] TBL_LIMIT = (ADDR_W-1)'(TBL_BYTES);

  logic [7:0]        sram [SRAM_DEPTH];
  logic              loading;
  logic [TBL_AW-1:0] ld_cnt;
  logic              srst;
  logic [IDX_W-1:0]  idx;

  wire rd_acc  = h_attr && h_rd;
  wire wr_acc  = h_attr && h_wr;
  wire cfg_hit = (ha == CFG_ADDR);
  wire in_tbl  = !ha[0] && (ha[ADDR_W-1:1] < TBL_LIMIT);
  wire store   = loading && ee_ack;
  wire [7:0] cor_val = {srst, 1'b1, idx};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      loading <= 1'b1;
      ld_cnt  <= '0;
    end else if (store) begin
      if (ld_cnt == LAST_IDX) loading <= 1'b0;
      else                    ld_cnt  <= ld_cnt + 1'b1;
    end

  always_ff @(posedge clk)
    if (store) sram[{1'b1, ld_cnt}] <= ee_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      srst <= 1'b0;
      idx  <= '0;
    end else if (wr_acc && cfg_hit) begin
      srst <= hd_in[7];
      if (!srst && !hd_in[7]) idx <= hd_in[IDX_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      hd_out <= 8'hFF;
    else if (rd_acc) begin
      if (cfg_hit)                hd_out <= cor_val;
      else if (in_tbl && !loading) hd_out <= sram[{1'b1, ha[TBL_AW:1]}];
      else                        hd_out <= 8'hFF;
    end

  assign busy     = loading;
  assign ee_req   = loading;
  assign ee_addr  = ld_cnt;
  assign soft_rst = srst;
  assign core_rst = srst || !rst_n;
endmodule

module pccard_attr_cfg_chk #(
  parameter logic [16:0] CFG_ADDR = 17'h00FD0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [16:0] ha,
  input logic [7:0]  hd_in,
  input logic [7:0]  hd_out,
  input logic        h_rd,
  input logic        h_wr,
  input logic        h_attr,
  input logic        busy,
  input logic        ee_req,
  input logic        soft_rst,
  input logic        core_rst
);
  AST_WR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_attr && ha == CFG_ADDR) |=> (soft_rst == $past(hd_in[7]))); // R6
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(busy)); // R8
  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ee_req); // R2
  AST_FLAG_IN_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> core_rst); // R10
  AST_ODD_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_attr && ha[0]) |=> (hd_out == 8'hFF)); // R4
  AST_HW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !soft_rst); // R9
  AST_NONATTR_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && !h_attr) |=> $stable(soft_rst)); // R11
endmodule

bind pccard_attr_cfg pccard_attr_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ha(ha), .hd_in(hd_in), .hd_out(hd_out),
  .h_rd(h_rd), .h_wr(h_wr), .h_attr(h_attr), .busy(busy), .ee_req(ee_req),
  .soft_rst(soft_rst), .core_rst(core_rst));

// File: tb/tb_pccard_attr_cfg.sv
module tb_pccard_attr_cfg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [16:0] ha = '0;
  logic [7:0]  hd_in = '0;
  logic [7:0]  hd_out;
  logic        h_rd = 0, h_wr = 0, h_attr = 0;
  logic        busy, ee_req, ee_ack = 0, soft_rst, core_rst;
  logic [8:0]  ee_addr;
  logic [7:0]  ee_data = '0;

  int n_cmp = 0, n_bad = 0, n_ack = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  pccard_attr_cfg dut (.*);

  function automatic logic [7:0] rom(int n);
    return 8'((n * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) ee_ack <= 1'b0;
    else begin
      ee_ack  <= ee_req && !ee_ack;
      ee_data <= rom(int'(ee_addr));
      if (ee_ack) n_ack++;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one clock after each attribute read
  initial forever begin
    @(posedge clk);
    if (h_rd && h_attr) begin
      @(negedge clk);
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), {24'h0, hd_out}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic host_read(logic [16:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    ha = a; h_rd = 1; h_attr = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    h_rd = 0; h_attr = 0;
  endtask

  task automatic host_write(logic [16:0] a, logic [7:0] d, logic attr);
    @(negedge clk);
    ha = a; hd_in = d; h_wr = 1; h_attr = attr;
    @(negedge clk);
    h_wr = 0; h_attr = 0;
  endtask

  task automatic wait_load();
    while (busy) @(negedge clk);
  endtask

  localparam logic [16:0] COR = 17'h00FD0;

  initial begin
    repeat (5) @(negedge clk);
    check("R1 busy in reset", busy, 1);
    check("R9 soft_rst in reset", soft_rst, 0);
    check("R10 core_rst in hw reset", core_rst, 1);
    rst_n = 1;
    host_read(COR, 8'h40, "R5 reset value");
    host_read(17'h0, 8'hFF, "R1 table while loading");
    check("R1 busy while loading", busy, 1);
    wait_load();
    check("R2 fetch count", n_ack, 492);
    check("R2 ee_req idle", ee_req, 0);
    check("R10 core_rst idle", core_rst, 0);
    host_read(17'h0, rom(0), "R3 byte 0");
    host_read(17'h2, rom(1), "R3 byte 1");
    host_read(17'd490, rom(245), "R3 byte 245");
    host_read(17'h3D6, rom(491), "R3 byte 491");
    host_read(17'h1, 8'hFF, "R4 odd offset");
    host_read(17'h3D9, 8'hFF, "R4 odd offset high");
    host_read(17'h3D8, 8'hFF, "R4 past table");
    host_read(17'h2000, 8'hFF, "R4 unmapped even");
    host_write(COR, 8'h3F, 1);
    host_read(COR, 8'h7F, "R5 index all ones");
    host_write(COR, 8'h0A, 1);
    host_read(COR, 8'h4A, "R5 bit6 reads one");
    host_write(COR, 8'h45, 1);
    host_read(COR, 8'h45, "R5 index five");
    host_write(COR, 8'h87, 0);
    check("R11 non-attr write flag", soft_rst, 0);
    host_read(COR, 8'h45, "R11 non-attr write ignored");
    @(negedge clk); ha = COR; h_rd = 1; h_attr = 0;
    @(negedge clk); h_rd = 0;
    check("R11 non-attr read holds output", hd_out, 8'h45);
    host_write(COR, 8'h9A, 1);
    check("R6 soft_rst set", soft_rst, 1);
    check("R6 core_rst set", core_rst, 1);
    host_read(COR, 8'hC5, "R6 index discarded");
    host_write(COR, 8'h83, 1);
    check("R7 flag held", soft_rst, 1);
    host_read(COR, 8'hC5, "R7 no change");
    n_ack = 0;
    host_write(COR, 8'h12, 1);
    check("R8 soft_rst released", soft_rst, 0);
    check("R8 core_rst released", core_rst, 0);
    host_read(COR, 8'h45, "R8 index preserved");
    host_read(17'hE, rom(7), "R8 table preserved");
    check("R8 busy stays low", busy, 0);
    check("R8 no fetch", n_ack, 0);
    host_write(COR, 8'h80, 1);
    check("R9 flag before hw reset", soft_rst, 1);
    @(negedge clk); rst_n = 0; #1;
    check("R9 flag cleared", soft_rst, 0);
    check("R10 core_rst in hw reset", core_rst, 1);
    check("R9 busy in reset", busy, 1);
    n_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    host_read(COR, 8'h40, "R9 register cleared");
    wait_load();
    check("R9 reload count", n_ack, 492);
    host_read(17'h3D6, rom(491), "R9 table reloaded");
    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule